// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the control sequencer of a successive-approximation converter. It runs on the divided converter clock. It takes an enable level, a start-request strobe, a continuous-mode select, a differential-input select and a reference-select field. For each conversion it chooses a short (normal) or long (extended) length. It counts the conversion cycles and fires a sample-and-hold strobe on a falling clock edge at the correct half-cycle point. When a conversion ends, it captures a result word from the external data path and raises a sticky completion flag.

The selections are captured at each conversion boundary, so a change made during a conversion applies only to the next one. A conversion with the differential input selected may begin only on alternate clock edges, counted from the moment the block was enabled. In continuous mode the next conversion begins at the same edge that completes the previous one. The comparator, the converter DAC, the clock divider and any register interface are outside this block.

The controller has three states:

| State | Meaning |
|---|---|
| `ST_OFF` | Disabled. |
| `ST_IDLE` | Enabled and waiting. |
| `ST_CONV` | Converting. |

Its transitions are:

| Transition | From | To | Cause |
|---|---|---|---|
| power-up | `ST_OFF` | `ST_IDLE` | `enable` is high. |
| launch | `ST_IDLE` | `ST_CONV` | The start bit is set and the phase allows it. |
| chain | `ST_CONV` | `ST_CONV` | The last cycle is reached in continuous mode and the phase allows it. |
| finish | `ST_CONV` | `ST_IDLE` | The last cycle is reached with no chaining. |
| shutdown | any state | `ST_OFF` | `enable` is low. |

Top module: `adc_seq_ctrl`

## Requirements
- R1: A start request sampled at one rising edge sets `start_bit`. The conversion launches at the next rising edge (differential input not selected), and `busy` goes high at that edge.
- R2: With `diff_sel` high, a conversion launches only at an edge that lies an odd number of clock periods after the first rising edge at which `enable` was sampled high.
- R3: A normal conversion keeps `busy` high for exactly NORM_LEN (13) clock periods.
- R4: An extended conversion lasts EXT_LEN (25) periods. It is chosen for the first conversion after `enable` rises, after `ref_sel` differs from the reference used last, or after `diff_sel` becomes newly selected. A repeat conversion on the same differential selection is normal. `ext_conv` is 1 for an extended conversion and holds until the next launch.
- R5: `sh_strobe` rises on a falling clock edge. It rises 1.5 periods after the launch edge of a normal conversion and 13.5 periods after the launch edge of an extended one. It stays high for one period.
- R6: At the completion edge, `result_q` takes `result_in` and `done_flag` is set.
- R7: In single mode (`free_run` = 0), `start_bit` clears at the completion edge.
- R8: `ref_act` and `diff_act` take `ref_sel` and `diff_sel` only at a launch edge. A change during a conversion leaves them unchanged.
- R9: `done_flag` stays set until `flag_clr` is high at an edge. If completion and `flag_clr` coincide, the flag ends up set.
- R10: A start request while `busy` is high, including at the completion edge, is ignored: no new conversion starts and `start_bit` ends up 0 in single mode.
- R11: `enable` low aborts any conversion at the next edge (`busy` 0, `start_bit` 0, flag untouched). It also forces the next conversion to be extended.
- R12: With `free_run` high, the next conversion launches at the completion edge, so `busy` stays high. Once `free_run` is low at a completion, the block stops and clears `start_bit`.
- R13: After reset, `busy`, `start_bit`, `sh_strobe`, `done_flag` and `result_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable level |
| start_set | input | 1 | One-cycle start request |
| free_run | input | 1 | Continuous conversion mode |
| diff_sel | input | 1 | Differential input selected |
| ref_sel | input | REF_W | Reference selection |
| flag_clr | input | 1 | Completion flag clear strobe |
| result_in | input | RES_W | Result word from the data path |
| busy | output | 1 | Conversion in progress |
| start_bit | output | 1 | Pending/active start bit |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| done_flag | output | 1 | Sticky completion flag |
| result_q | output | RES_W | Captured result |
| ext_conv | output | 1 | Latest conversion is extended |
| ref_act | output | REF_W | Reference in use |
| diff_act | output | 1 | Differential mode in use |

## Verification
The hardest situations to reach from the ports are the coincidences at the completion edge: a start request or a flag clear in the same cycle as completion, and the parity rule for differential launches. The bench times each such stimulus from the recorded time of the `busy` rising edge, so that it is held exactly across the completion edge. For the parity rule, it records the first enabled edge and then issues differential start requests at two different alignments, checking that each launch lands on the permitted parity. The half-cycle strobe position is measured as a time difference to the launch edge, rather than by sampling at a clock edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_seq_mode.sv
// Decides the kind of the next conversion and tracks the alternate-edge phase.
module adc_seq_mode #(
    parameter int REF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             launch,
    input  logic             diff_sel,
    input  logic [REF_W-1:0] ref_sel,
    output logic             phase_odd,
    output logic             phase_ok,
    output logic             ext_now,
    output logic             diff_act,
    output logic [REF_W-1:0] ref_act
);

    logic             phase_q;
    logic             arm_q;
    logic             diff_q;
    logic [REF_W-1:0] ref_q;

    // Phase toggles on every enabled edge; cleared while disabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (!enable) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    // Extended-conversion arm: set while disabled, consumed by a launch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b1;
        end else if (!enable) begin
            arm_q <= 1'b1;
        end else if (launch) begin
            arm_q <= 1'b0;
        end
    end

    // Selections captured only at a conversion boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q <= 1'b0;
            ref_q  <= '0;
        end else if (launch) begin
            diff_q <= diff_sel;
            ref_q  <= ref_sel;
        end
    end

    always_comb begin
        ext_now   = arm_q | (ref_sel != ref_q) | (diff_sel & ~diff_q);
        phase_ok  = ~diff_sel | phase_q;
        phase_odd = phase_q;
        diff_act  = diff_q;
        ref_act   = ref_q;
    end

    // R11: a disabled cycle must leave the next conversion marked extended
    p_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ext_now);

    // R8: the captured selections move only on a launch
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(ref_act) && $stable(diff_act)));

endmodule

// File: rtl/adc_seq_timer.sv
// Conversion cycle counter and falling-edge sample-and-hold strobe.
module adc_seq_timer #(
    parameter int NORM_LEN = 13,
    parameter int EXT_LEN  = 25,
    parameter int SH_NORM  = 1,
    parameter int SH_EXT   = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic cont,
    input  logic ext_now,
    output logic last,
    output logic ext_kind,
    output logic sh_strobe
);

    localparam int CNT_W = $clog2(EXT_LEN + 1);
    localparam logic [CNT_W-1:0] NORM_END = CNT_W'(NORM_LEN);
    localparam logic [CNT_W-1:0] EXT_END  = CNT_W'(EXT_LEN);
    localparam logic [CNT_W-1:0] SH_N_IDX = CNT_W'(SH_NORM + 1);
    localparam logic [CNT_W-1:0] SH_E_IDX = CNT_W'(SH_EXT + 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_end;
    logic [CNT_W-1:0] sh_idx;
    logic             ext_q;
    logic             sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ext_q <= 1'b0;
        end else if (launch) begin
            cnt_q <= ONE;
            ext_q <= ext_now;
        end else if (cont) begin
            cnt_q <= cnt_q + ONE;
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        len_end = ext_q ? EXT_END : NORM_END;
        sh_idx  = ext_q ? SH_E_IDX : SH_N_IDX;
        last    = (cnt_q == len_end);
    end

    // Strobe launched half a period into the cycle following the sampling point.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= 1'b0;
        end else begin
            sh_q <= (cnt_q == sh_idx);
        end
    end

    always_comb begin
        ext_kind  = ext_q;
        sh_strobe = sh_q;
    end

    // R3: the cycle count never runs past the conversion length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= len_end);

    // R5: the strobe is only ever seen while a conversion is counting
    p_sh_in_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe |-> (cnt_q != '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int REF_W    = 2,
    parameter int NORM_LEN = 13,
    parameter int EXT_LEN  = 25,
    parameter int SH_NORM  = 1,
    parameter int SH_EXT   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_set,
    input  logic             free_run,
    input  logic             diff_sel,
    input  logic [REF_W-1:0] ref_sel,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] result_in,
    output logic             busy,
    output logic             start_bit,
    output logic             sh_strobe,
    output logic             done_flag,
    output logic [RES_W-1:0] result_q,
    output logic             ext_conv,
    output logic [REF_W-1:0] ref_act,
    output logic             diff_act
);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             start_q;
    logic             done_q;
    logic [RES_W-1:0] res_q;
    logic             launch;
    logic             complete;
    logic             cont;
    logic             last;
    logic             phase_ok;
    logic             phase_odd;
    logic             ext_now;
    logic             ext_kind;
    logic             sh_w;

    adc_seq_mode #(
        .REF_W (REF_W)
    ) mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .launch    (launch),
        .diff_sel  (diff_sel),
        .ref_sel   (ref_sel),
        .phase_odd (phase_odd),
        .phase_ok  (phase_ok),
        .ext_now   (ext_now),
        .diff_act  (diff_act),
        .ref_act   (ref_act)
    );

    adc_seq_timer #(
        .NORM_LEN (NORM_LEN),
        .EXT_LEN  (EXT_LEN),
        .SH_NORM  (SH_NORM),
        .SH_EXT   (SH_EXT)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cont      (cont),
        .ext_now   (ext_now),
        .last      (last),
        .ext_kind  (ext_kind),
        .sh_strobe (sh_w)
    );

    // Next-state and sequencing decisions.
    always_comb begin
        state_d  = state_q;
        launch   = 1'b0;
        complete = 1'b0;
        cont     = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (enable) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (start_q && phase_ok) begin
                    launch  = 1'b1;
                    state_d = ST_CONV;
                end
            end
            ST_CONV: begin
                if (last) begin
                    complete = 1'b1;
                    if (free_run && start_q && phase_ok) begin
                        launch = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cont = 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase
        if (!enable) begin
            state_d  = ST_OFF;
            launch   = 1'b0;
            complete = 1'b0;
            cont     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Start bit: set by a request outside a conversion, cleared by single-mode completion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else if (!enable) begin
            start_q <= 1'b0;
        end else if (complete && !free_run) begin
            start_q <= 1'b0;
        end else if (start_set && state_q != ST_CONV) begin
            start_q <= 1'b1;
        end
    end

    // Completion flag (set has priority) and result capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            if (complete) begin
                done_q <= 1'b1;
                res_q  <= result_in;
            end else if (flag_clr) begin
                done_q <= 1'b0;
            end
        end
    end

    // Output process.
    always_comb begin
        busy      = (state_q == ST_CONV);
        start_bit = start_q;
        sh_strobe = sh_w;
        done_flag = done_q;
        result_q  = res_q;
        ext_conv  = ext_kind;
    end

    // R6: the flag is raised right after a completion edge
    p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> done_flag);

    // R7: single-mode completion drops the start bit
    p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !free_run) |=> !start_bit);

    // R11: disabling ends any conversion and the pending start
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !start_bit));

    // R2: a differential conversion begins only on a permitted phase
    p_diff_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && diff_act) |-> $past(phase_odd));

    // R5: no strobe is pending while the block sits outside a conversion
    p_sh_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> !sh_strobe);

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  RES_W      = 10;
    localparam int  REF_W      = 2;
    localparam int  NORM_LEN   = 13;
    localparam int  EXT_LEN    = 25;
    localparam int  SH_NORM    = 1;
    localparam int  SH_EXT     = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             start_set = 1'b0;
    logic             free_run = 1'b0;
    logic             diff_sel = 1'b0;
    logic [REF_W-1:0] ref_sel = '0;
    logic             flag_clr = 1'b0;
    logic [RES_W-1:0] result_in = '0;
    logic             busy;
    logic             start_bit;
    logic             sh_strobe;
    logic             done_flag;
    logic [RES_W-1:0] result_q;
    logic             ext_conv;
    logic [REF_W-1:0] ref_act;
    logic             diff_act;

    int     n_checks = 0;
    int     n_errors = 0;
    longint t_rise   = 0;
    longint t_fall   = 0;
    longint t_sh     = -1;
    longint t_en1    = 0;
    longint t_set    = 0;

    adc_seq_ctrl #(
        .RES_W    (RES_W),
        .REF_W    (REF_W),
        .NORM_LEN (NORM_LEN),
        .EXT_LEN  (EXT_LEN),
        .SH_NORM  (SH_NORM),
        .SH_EXT   (SH_EXT)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start_set (start_set),
        .free_run  (free_run),
        .diff_sel  (diff_sel),
        .ref_sel   (ref_sel),
        .flag_clr  (flag_clr),
        .result_in (result_in),
        .busy      (busy),
        .start_bit (start_bit),
        .sh_strobe (sh_strobe),
        .done_flag (done_flag),
        .result_q  (result_q),
        .ext_conv  (ext_conv),
        .ref_act   (ref_act),
        .diff_act  (diff_act)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge busy)      t_rise = $time;
    always @(negedge busy)      t_fall = $time;
    always @(posedge sh_strobe) t_sh   = $time;

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Pulse a start request; t_set is the edge that samples it.
    task automatic start_pulse();
        start_set = 1'b1;
        @(posedge clk);
        t_set = $time;
        #1;
        start_set = 1'b0;
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 10; i++) begin
            if (busy) break;
            tick();
        end
    endtask

    task automatic wait_fall();
        for (int i = 0; i < 40; i++) begin
            if (!busy) break;
            tick();
        end
    endtask

    // Move to 2 time units after the n-th edge following the launch edge.
    task automatic at_cycle(input longint n);
        #(t_rise + n * CLK_PERIOD + 2 - $time);
    endtask

    task automatic check_conv(input bit ext, input logic [RES_W-1:0] exp_res,
                              input string tag);
        longint len_exp = ext ? EXT_LEN : NORM_LEN;
        longint sh_exp  = ext ? ((2 * SH_EXT + 1) * CLK_PERIOD) / 2
                              : ((2 * SH_NORM + 1) * CLK_PERIOD) / 2;
        chk({tag, " R3/R4 length"}, (t_fall - t_rise) / CLK_PERIOD, len_exp);
        chk({tag, " R4 ext_conv"}, longint'(ext_conv), longint'(ext));
        chk({tag, " R5 strobe offset"}, t_sh - t_rise, sh_exp);
        chk({tag, " R6 done_flag"}, longint'(done_flag), 1);
        chk({tag, " R6 result"}, longint'(result_q), longint'(exp_res));
        chk({tag, " R7 start_bit cleared"}, longint'(start_bit), 0);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic test_reset();
        chk("R13 busy", longint'(busy), 0);
        chk("R13 start_bit", longint'(start_bit), 0);
        chk("R13 sh_strobe", longint'(sh_strobe), 0);
        chk("R13 done_flag", longint'(done_flag), 0);
        chk("R13 result_q", longint'(result_q), 0);
    endtask

    task automatic test_first_extended();
        enable = 1'b1;
        @(posedge clk);
        t_en1 = $time;
        #1;
        tick();
        result_in = 10'h2A5;
        t_sh = -1;
        start_pulse();
        chk("R1 start_bit set", longint'(start_bit), 1);
        wait_rise();
        chk("R1 launch edge", t_rise - t_set, CLK_PERIOD);
        wait_fall();
        check_conv(1'b1, 10'h2A5, "after-enable");
    endtask

    task automatic test_normal_and_clear();
        clear_flag();
        chk("R9 flag cleared", longint'(done_flag), 0);
        result_in = 10'h133;
        t_sh = -1;
        start_pulse();
        wait_rise();
        chk("R1 launch edge normal", t_rise - t_set, CLK_PERIOD);
        wait_fall();
        check_conv(1'b0, 10'h133, "repeat");
    endtask

    task automatic test_ref_change();
        clear_flag();
        ref_sel = 2'd1;
        result_in = 10'h0F0;
        t_sh = -1;
        start_pulse();
        wait_rise();
        at_cycle(5);
        ref_sel = 2'd2;
        #1;
        chk("R8 ref_act held mid-conversion", longint'(ref_act), 1);
        wait_fall();
        check_conv(1'b1, 10'h0F0, "ref-change");
        tick();
        result_in = 10'h00F;
        t_sh = -1;
        start_pulse();
        wait_rise();
        wait_fall();
        check_conv(1'b1, 10'h00F, "ref-change-late");
        chk("R8 ref_act updated at launch", longint'(ref_act), 2);
        tick();
        t_sh = -1;
        start_pulse();
        wait_rise();
        wait_fall();
        check_conv(1'b0, 10'h00F, "ref-steady");
    endtask

    task automatic test_completion_edge();
        clear_flag();
        result_in = 10'h155;
        start_pulse();
        wait_rise();
        at_cycle(NORM_LEN - 1);
        start_set = 1'b1;
        flag_clr  = 1'b1;
        at_cycle(NORM_LEN);
        start_set = 1'b0;
        flag_clr  = 1'b0;
        chk("R9 set wins over clear", longint'(done_flag), 1);
        chk("R6 result at completion", longint'(result_q), 10'h155);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R10 no launch from busy request", longint'(busy), 0);
        end
        chk("R10 start_bit stays clear", longint'(start_bit), 0);
        clear_flag();
        chk("R9 clear after set", longint'(done_flag), 0);
    endtask

    task automatic test_free_run();
        free_run  = 1'b1;
        result_in = 10'h111;
        start_pulse();
        wait_rise();
        at_cycle(NORM_LEN);
        chk("R12 busy across boundary", longint'(busy), 1);
        chk("R12 first result", longint'(result_q), 10'h111);
        chk("R12 start_bit kept", longint'(start_bit), 1);
        result_in = 10'h222;
        at_cycle(NORM_LEN + 5);
        chk("R12 still converting", longint'(busy), 1);
        free_run = 1'b0;
        at_cycle(2 * NORM_LEN);
        chk("R12 stopped after mode off", longint'(busy), 0);
        chk("R12 second result", longint'(result_q), 10'h222);
        chk("R12 start_bit cleared", longint'(start_bit), 0);
        clear_flag();
    endtask

    task automatic test_differential();
        diff_sel  = 1'b1;
        result_in = 10'h3C3;
        t_sh = -1;
        start_pulse();
        wait_rise();
        chk("R2 launch parity first", ((t_rise - t_en1) / CLK_PERIOD) % 2, 1);
        chk("R8 diff_act latched", longint'(diff_act), 1);
        wait_fall();
        check_conv(1'b1, 10'h3C3, "diff-new");
        tick();
        tick();
        t_sh = -1;
        start_pulse();
        wait_rise();
        chk("R2 launch parity second", ((t_rise - t_en1) / CLK_PERIOD) % 2, 1);
        wait_fall();
        check_conv(1'b0, 10'h3C3, "diff-repeat");
        tick();
        t_sh = -1;
        start_pulse();
        wait_rise();
        chk("R2 launch parity third", ((t_rise - t_en1) / CLK_PERIOD) % 2, 1);
        wait_fall();
        diff_sel = 1'b0;
        clear_flag();
    endtask

    task automatic test_abort();
        result_in = 10'h0AA;
        start_pulse();
        wait_rise();
        at_cycle(5);
        enable = 1'b0;
        at_cycle(6);
        chk("R11 busy dropped", longint'(busy), 0);
        chk("R11 start_bit dropped", longint'(start_bit), 0);
        chk("R11 flag untouched", longint'(done_flag), 0);
        tick();
        enable = 1'b1;
        tick();
        t_sh = -1;
        start_pulse();
        wait_rise();
        wait_fall();
        check_conv(1'b1, 10'h0AA, "post-abort R11");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_first_extended();
        test_normal_and_clear();
        test_ref_change();
        test_completion_edge();
        test_free_run();
        test_differential();
        test_abort();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule